// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block sets the frame timing of a time-division-multiplexed audio port. It runs in the system clock domain. A one-cycle bit-clock enable tick marks each bit period on the serial line. The block keeps track of where each bit falls in the frame and reports it through four outputs: the frame sync line, a strobe at the first bit of each active slot, the index of the slot in progress, and a strobe at the first bit of each frame.

As clock master, the block drives the frame sync itself. The sync can be a one-bit pulse, placed either on the first bit of slot 0 or on the bit just before it. It can also be a long pulse that covers the whole of slot 0. As clock follower, it keeps its own sync output low and watches an external sync input. A rising edge of that input, seen at a tick, sets the position to the first bit of slot 0.

Before frame activity starts, the block checks that the divider can hold all active slots. An invalid setting sets a sticky error flag, and the block then stays silent until reset.

Top module: `tdm_fsync_gen`

## Requirements
- R1: With the block running, the frame is `frame_div`+1 bit ticks long, and `frame_start` pulses on the first bit of every frame.
- R2: In short-sync mode (`long_sync`=0) with late placement (`early_sync`=0), `fsync_out` is high for exactly the one bit tick of frame position 0.
- R3: In short-sync mode with early placement (`early_sync`=1), `fsync_out` is high only for the last bit of the frame, at position `frame_div`, which is one bit tick before slot 0.
- R4: In long-sync mode (`long_sync`=1), `fsync_out` is high for frame positions 0 through `slot_len`-1.
- R5: `slot_start` pulses at frame positions k·`slot_len` for k from 0 to `slot_cnt`-1, and `slot_idx` then takes the value k. The bits after the last active slot give no `slot_start`.
- R6: While `enable`=0, all outputs are low and `slot_idx` is 0. After `enable` rises, the first tick is frame position 0.
- R7: `cfg_err` is set in the cycle after a clock edge at which `enable`=1 while the setting is invalid. A setting is invalid when `slot_len`=0, when `slot_cnt`=0, when `frame_div`+1 < `slot_len`·`slot_cnt`, or when long sync is selected with `slot_cnt`=1 and `frame_div`+1 ≤ `slot_len`. Only reset clears the flag. While it is set, every output stays low.
- R8: In follower mode (`slave_mode`=1), `fsync_out` stays low and no strobes appear until `ext_sync` is seen rising at a tick. The bit at that tick is frame position 0.
- R9: In follower mode, a rising edge of `ext_sync` at any later tick moves the position back to 0, even in the middle of a frame.
- R10: After reset, all outputs are 0. `slot_start` and `frame_start` last one clock cycle and appear only in the cycle after a tick.
- R11: In long-sync mode, the value of `early_sync` has no effect on `fsync_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_tick | input | 1 | One-cycle pulse per bit period |
| enable | input | 1 | Global run enable |
| slave_mode | input | 1 | 0 = drive sync, 1 = follow `ext_sync` |
| long_sync | input | 1 | 0 = one-bit sync, 1 = slot-long sync |
| early_sync | input | 1 | Short sync placement: 0 = on slot 0, 1 = one bit before |
| frame_div | input | DIV_W | Frame length minus one, in bits |
| slot_len | input | SLEN_W | Bits per slot |
| slot_cnt | input | SCNT_W | Number of active slots |
| ext_sync | input | 1 | External frame sync (follower mode) |
| fsync_out | output | 1 | Generated frame sync |
| slot_start | output | 1 | Strobe at first bit of an active slot |
| slot_idx | output | SCNT_W | Index of the current slot |
| frame_start | output | 1 | Strobe at first bit of a frame |
| cfg_err | output | 1 | Sticky invalid-setting flag |

## Verification
Every timing output is registered at the clock edge where the tick is sampled, so its value for a bit shows up in the next clock cycle. `fsync_out` and `slot_idx` then hold until the next tick, while the strobes drop after one cycle. `cfg_err` and the silencing of the outputs both appear one cycle after the edge that sees the bad setting. The same holds for the cycle after `enable` falls. The bench model steps on the same rising edge from the same input values, and every output is compared at the following falling edge. This means each value is checked in the exact cycle it becomes due.

// File: rtl/tdm_fsync_pkg.sv
package tdm_fsync_pkg;
  typedef enum logic {ROLE_MASTER = 1'b0, ROLE_SLAVE = 1'b1} role_e;
  typedef enum logic {SYNC_SHORT = 1'b0, SYNC_LONG = 1'b1} sync_e;
endpackage

// File: rtl/tdm_fsync_cfgchk.sv
module tdm_fsync_cfgchk #(
  parameter int DIV_W  = 10,
  parameter int SLEN_W = 6,
  parameter int SCNT_W = 4
) (
  input  logic [DIV_W-1:0]  frame_div,
  input  logic [SLEN_W-1:0] slot_len,
  input  logic [SCNT_W-1:0] slot_cnt,
  input  logic              long_sync,
  output logic              cfg_ok
);
  localparam int PW = SLEN_W + SCNT_W;
  localparam int CW = (PW > DIV_W + 1) ? PW : DIV_W + 1;

  logic [CW-1:0] period, need, len_w;

  always_comb begin
    period = CW'(frame_div) + CW'(1);
    len_w  = CW'(slot_len);
    need   = len_w * CW'(slot_cnt);
    cfg_ok = (slot_len != '0) && (slot_cnt != '0) && (period >= need) &&
             !(long_sync && (slot_cnt == SCNT_W'(1)) && (period <= len_w));
  end
endmodule

// File: rtl/tdm_fsync_edge.sv
module tdm_fsync_edge (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic ext_sync,
  output logic sync_rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst)       prev_q <= 1'b0;
    else if (tick) prev_q <= ext_sync;
  end

  assign sync_rise = tick && ext_sync && !prev_q;
endmodule

// File: rtl/tdm_fsync_core.sv
module tdm_fsync_core #(
  parameter int DIV_W  = 10,
  parameter int SLEN_W = 6,
  parameter int SCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              slave,
  input  logic              long_sync,
  input  logic              early,
  input  logic              sync_rise,
  input  logic [DIV_W-1:0]  frame_div,
  input  logic [SLEN_W-1:0] slot_len,
  input  logic [SCNT_W-1:0] slot_cnt,
  output logic              fsync,
  output logic              slot_start,
  output logic              frame_start,
  output logic [SCNT_W-1:0] slot_idx
);
  localparam int CW = (DIV_W > SLEN_W) ? DIV_W : SLEN_W;

  logic [DIV_W-1:0]  pos_q, cur_pos;
  logic [SLEN_W-1:0] bis_q, cur_bis;
  logic [SCNT_W-1:0] slot_q, cur_slot;
  logic locked_q, restart, active, frame_end, slot_end, in_slots, fs_val;

  always_comb begin
    restart   = slave && sync_rise;
    active    = tick && (!slave || locked_q || sync_rise);
    cur_pos   = restart ? '0 : pos_q;
    cur_bis   = restart ? '0 : bis_q;
    cur_slot  = restart ? '0 : slot_q;
    frame_end = (cur_pos == frame_div);
    slot_end  = (cur_bis == slot_len - 1'b1);
    in_slots  = (cur_slot < slot_cnt);
    if (long_sync)  fs_val = CW'(cur_pos) < CW'(slot_len);
    else if (early) fs_val = frame_end;
    else            fs_val = (cur_pos == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pos_q <= '0; bis_q <= '0; slot_q <= '0; locked_q <= 1'b0;
      fsync <= 1'b0; slot_start <= 1'b0; frame_start <= 1'b0; slot_idx <= '0;
    end else begin
      slot_start  <= 1'b0;
      frame_start <= 1'b0;
      if (slave)       fsync <= 1'b0;
      else if (active) fsync <= fs_val;
      if (active) begin
        frame_start <= (cur_pos == '0);
        if (cur_bis == '0 && in_slots) begin
          slot_start <= 1'b1;
          slot_idx   <= cur_slot;
        end
        if (frame_end) begin
          pos_q <= '0; bis_q <= '0; slot_q <= '0;
        end else begin
          pos_q <= cur_pos + 1'b1;
          if (slot_end) begin
            bis_q  <= '0;
            slot_q <= in_slots ? cur_slot + 1'b1 : cur_slot;
          end else begin
            bis_q  <= cur_bis + 1'b1;
            slot_q <= cur_slot;
          end
        end
        if (slave) locked_q <= 1'b1;
      end
    end
  end

  // R10
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_start || frame_start) |-> $past(tick));
  // R5
  frame_has_slot_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> slot_start && slot_idx == '0);
  // R8
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    slave |=> !fsync);
  // R2
  late_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start && $past(!long_sync && !early && !slave) |-> fsync);
endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
  import tdm_fsync_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int SLEN_W = 6,
  parameter int SCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_tick,
  input  logic              enable,
  input  logic              slave_mode,
  input  logic              long_sync,
  input  logic              early_sync,
  input  logic [DIV_W-1:0]  frame_div,
  input  logic [SLEN_W-1:0] slot_len,
  input  logic [SCNT_W-1:0] slot_cnt,
  input  logic              ext_sync,
  output logic              fsync_out,
  output logic              slot_start,
  output logic [SCNT_W-1:0] slot_idx,
  output logic              frame_start,
  output logic              cfg_err
);
  role_e role;
  sync_e smode;
  logic  cfg_ok, sync_rise, run;

  assign role  = role_e'(slave_mode);
  assign smode = sync_e'(long_sync);

  tdm_fsync_cfgchk #(.DIV_W(DIV_W), .SLEN_W(SLEN_W), .SCNT_W(SCNT_W)) u_chk (
    .frame_div(frame_div), .slot_len(slot_len), .slot_cnt(slot_cnt),
    .long_sync(smode == SYNC_LONG), .cfg_ok(cfg_ok));

  tdm_fsync_edge u_edge (
    .clk(clk), .rst(rst), .tick(bclk_tick), .ext_sync(ext_sync), .sync_rise(sync_rise));

  always_ff @(posedge clk) begin
    if (rst)                      cfg_err <= 1'b0;
    else if (enable && !cfg_ok)   cfg_err <= 1'b1;
  end

  assign run = enable && !cfg_err && cfg_ok;

  tdm_fsync_core #(.DIV_W(DIV_W), .SLEN_W(SLEN_W), .SCNT_W(SCNT_W)) u_core (
    .clk(clk), .rst(rst), .run(run), .tick(bclk_tick),
    .slave(role == ROLE_SLAVE), .long_sync(smode == SYNC_LONG), .early(early_sync),
    .sync_rise(sync_rise), .frame_div(frame_div), .slot_len(slot_len), .slot_cnt(slot_cnt),
    .fsync(fsync_out), .slot_start(slot_start), .frame_start(frame_start), .slot_idx(slot_idx));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !fsync_out && !slot_start && !frame_start);
  // R6
  disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !fsync_out && !slot_start && !frame_start && slot_idx == '0);
endmodule

// File: tb/tdm_fsync_gen_tb.sv
module tdm_fsync_gen_tb;
  logic clk = 0, rst = 1;
  logic tick = 0, en = 0, slv = 0, lng = 0, erl = 0, ext = 0;
  logic [9:0] div = 15;
  logic [5:0] len = 4;
  logic [3:0] cnt = 3;
  logic fsync, sstart, fstart, err;
  logic [3:0] idx;
  int checks = 0, errors = 0, cyc = 0, nfs = 0;
  string cur_req = "R10";

  // model state
  int m_fsync = 0, m_ss = 0, m_fs = 0, m_idx = 0, m_err = 0;
  int mpos = 0, mprev = 0, mlock = 0;

  always #10 clk = ~clk;

  tdm_fsync_gen u_dut (
    .clk(clk), .rst(rst), .bclk_tick(tick), .enable(en), .slave_mode(slv),
    .long_sync(lng), .early_sync(erl), .frame_div(div), .slot_len(len),
    .slot_cnt(cnt), .ext_sync(ext), .fsync_out(fsync), .slot_start(sstart),
    .slot_idx(idx), .frame_start(fstart), .cfg_err(err));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int p, rise, ok, run;
    if (rst) begin
      m_fsync = 0; m_ss = 0; m_fs = 0; m_idx = 0; m_err = 0;
      mpos = 0; mprev = 0; mlock = 0;
    end else begin
      ok = (len != 0) && (cnt != 0) && (int'(div) + 1 >= int'(len) * int'(cnt)) &&
           !(lng && cnt == 1 && int'(div) + 1 <= int'(len));
      run = en && !m_err && ok;
      if (en && !ok) m_err = 1;
      rise = tick && ext && !mprev;
      if (tick) mprev = ext;
      m_ss = 0; m_fs = 0;
      if (!run) begin
        m_fsync = 0; m_idx = 0; mpos = 0; mlock = 0;
      end else begin
        if (slv) m_fsync = 0;
        if (tick && (!slv || mlock || rise)) begin
          p = (slv && rise) ? 0 : mpos;
          m_fs = (p == 0);
          if (p % len == 0 && p / len < cnt) begin m_ss = 1; m_idx = p / len; end
          if (!slv) m_fsync = lng ? (p < len) : (erl ? (p == div) : (p == 0));
          mpos = (p == div) ? 0 : p + 1;
          if (slv) mlock = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "fsync_out", fsync, m_fsync);
      chk(cur_req, "slot_start", sstart, m_ss);
      chk(cur_req, "frame_start", fstart, m_fs);
      chk(cur_req, "slot_idx", idx, m_idx);
      chk(cur_req, "cfg_err", err, m_err);
      if (fstart) nfs++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R10 watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic slave_ticks(int n, int period, int phase);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin tick = 1; ext = (i % period == phase); end
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) begin rst = 1; en = 0; tick = 0; ext = 0; end
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    cur_req = "R10";
    chk("R10", "reset fsync_out", fsync, 0);
    chk("R10", "reset slot_idx", idx, 0);
    chk("R10", "reset cfg_err", err, 0);

    // R2 R5 R1: short late, 3 slots of 4 in a 16-bit frame
    cur_req = "R2"; div = 15; len = 4; cnt = 3; lng = 0; erl = 0; slv = 0;
    @(negedge clk) en = 1;
    nfs = 0;
    ticks(48, 0);
    @(negedge clk);
    chk("R1", "frame count over 48 ticks", nfs, 3);

    // R3: early placement, spaced ticks
    cur_req = "R3"; en = 0; @(negedge clk) erl = 1;
    @(negedge clk) en = 1;
    ticks(40, 1);

    // R4 R11: long sync, early ignored
    cur_req = "R4"; en = 0; @(negedge clk) begin div = 9; len = 4; cnt = 2; lng = 1; erl = 0; end
    @(negedge clk) en = 1;
    ticks(25, 2);
    cur_req = "R11"; en = 0; @(negedge clk) erl = 1;
    @(negedge clk) en = 1;
    ticks(25, 0);

    // R6: disable mid-frame and restart
    cur_req = "R6"; en = 0; @(negedge clk) begin lng = 0; erl = 0; div = 15; cnt = 3; end
    @(negedge clk) en = 1;
    ticks(7, 0);
    @(negedge clk) en = 0;
    repeat (3) @(negedge clk);
    chk("R6", "fsync while disabled", fsync, 0);
    en = 1;
    ticks(1, 0);
    chk("R6", "frame_start on first tick", fstart, 1);
    ticks(20, 0);

    // R8 R9: follower mode
    cur_req = "R8"; en = 0; @(negedge clk) slv = 1;
    @(negedge clk) en = 1;
    ticks(5, 0);
    chk("R8", "no strobe before sync", sstart, 0);
    slave_ticks(40, 16, 3);
    cur_req = "R9";
    slave_ticks(30, 16, 7);

    // R5: frame length exactly slots
    cur_req = "R5"; en = 0; @(negedge clk) begin slv = 0; div = 11; len = 4; cnt = 3; end
    @(negedge clk) en = 1;
    ticks(30, 0);
    chk("R5", "exact fit no error", err, 0);

    // R7: too-short divider
    cur_req = "R7"; en = 0; @(negedge clk) div = 10;
    @(negedge clk) en = 1;
    ticks(6, 0);
    chk("R7", "cfg_err set", err, 1);
    @(negedge clk) div = 15;
    ticks(6, 0);
    chk("R7", "cfg_err sticky", err, 1);

    // R7: long sync single slot boundary
    do_reset();
    cur_req = "R7"; lng = 1; erl = 0; slv = 0; len = 8; cnt = 1; div = 8;
    @(negedge clk) en = 1;
    ticks(20, 0);
    chk("R7", "long single slot valid", err, 0);
    en = 0; @(negedge clk) div = 7;
    @(negedge clk) en = 1;
    ticks(3, 0);
    chk("R7", "long single slot invalid", err, 1);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule